// File: doc/BRIEF.md
# Vector Issue Reservation Scoreboard

This block decides, cycle by cycle, whether the decoded vector operation waiting at its input may start. It serves a register-to-register vector unit with eight vector registers and six pipelined functional units. The offered operation names a functional unit, a destination register, a first source register and an optional second source register. It also carries the vector length.

When an operation starts, the block reserves every register it names and the unit it uses. Each resource stays reserved for a span fixed by the unit's latency plus the vector length, so the moment of release is fully predictable. A dependent operation may also start early on a chained path, in the single cycle when the producer's first element result appears. The block holds no data. The upstream stage offers operations with a valid/ready pair, and the per-register and per-unit busy flags are visible on the ports.

Top module: `vec_issue_sb`

## Requirements
- R1: At most one operation starts per clock: it starts on a rising edge exactly when `in_valid` and `in_ready` are both high on that edge, and `issue` shows `in_valid & in_ready`. With `in_valid` low nothing is reserved.
- R2: On a start, the destination, the first source, the second source (only when `in_use_b` is 1) and the unit are marked busy, and their flags read high in the cycle after the start edge.
- R3: Two operations that share no register and use different units start on consecutive edges with no stall.
- R4: An operation whose destination or non-chained source is busy stalls. Resources taken on edge P by an operation of latency L and length VL are free again for a start on edge P+L+VL. The busy flag is high for L+VL-1 cycles.
- R5: An operation whose unit is busy stalls until that unit is released, even when all its registers are free.
- R6: Unit codes and latencies in clocks: 0 vector add 3, 1 vector shift 4, 2 vector logical 2, 3 floating-point add 6, 4 floating-point multiply 7, 5 reciprocal approximation 14.
- R7: If a source is the destination of a producer started on edge P with VL greater than 0, and no other operation has yet read that register, the dependent operation may start on edge P+L exactly. A busy destination never chains.
- R8: A dependent operation that is offered after edge P+L has missed the chained slot and waits for the full release of R4.
- R9: The vector length is sampled at start. A length of 0 releases resources after the latency alone, and any length above 64 is treated as 64.
- R10: Unit codes 6 and 7 are never ready and reserve nothing.
- R11: A chained read re-reserves the shared register until the later of the producer's and the reader's release. Later readers of that register get no chained slot.
- R12: Reset clears all reservations. After reset every flag is low and any valid operation is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is offered |
| in_unit | input | 3 | Functional unit code |
| in_dst | input | 3 | Destination register |
| in_src_a | input | 3 | First source register |
| in_src_b | input | 3 | Second source register |
| in_use_b | input | 1 | Second source is used |
| in_vl | input | 7 | Vector length (0 to 64, larger is clamped) |
| in_ready | output | 1 | The offered operation may start |
| issue | output | 1 | The operation starts on this edge |
| reg_busy | output | 8 | Busy flag per vector register |
| unit_busy | output | 6 | Busy flag per functional unit |

## Verification
Two situations can fall in the same cycle. In the first, a chained slot opens on a source while the needed unit is still held. In the second, a chained read must merge the producer's remaining reservation with the reader's new one on a single edge. The bench sets these up with a fixed program in which a reader waits on a chained slot, a unit release and a register release that land on different edges. It judges each case only by the number of stall cycles before the start edge. Other rows then check that the merged reservation released on the later of the two edges and did not open a second chained slot.

// File: rtl/vec_issue_sb.sv
module vec_issue_sb #(
  parameter int NREG  = 8,
  parameter int NUNIT = 6,
  parameter int MAXVL = 64,
  localparam int RW   = $clog2(NREG),
  localparam int UW   = $clog2(NUNIT),
  localparam int VLW  = $clog2(MAXVL + 1),
  localparam int CW   = $clog2(MAXVL + 15),
  localparam int UPAD = 1 << UW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [UW-1:0]    in_unit,
  input  logic [RW-1:0]    in_dst,
  input  logic [RW-1:0]    in_src_a,
  input  logic [RW-1:0]    in_src_b,
  input  logic             in_use_b,
  input  logic [VLW-1:0]   in_vl,
  output logic             in_ready,
  output logic             issue,
  output logic [NREG-1:0]  reg_busy,
  output logic [NUNIT-1:0] unit_busy
);

  function automatic logic [4:0] lat_of(input logic [UW-1:0] u);
    case (u)
      0:       return 5'd3;
      1:       return 5'd4;
      2:       return 5'd2;
      3:       return 5'd6;
      4:       return 5'd7;
      5:       return 5'd14;
      default: return 5'd0;
    endcase
  endfunction

  logic [VLW-1:0]  vl_eff;
  logic [CW-1:0]   load;
  logic [UPAD-1:0] ubx;
  logic [NREG-1:0] win;
  logic            unit_ok, a_ok, b_ok;

  assign vl_eff  = (in_vl > VLW'(MAXVL)) ? VLW'(MAXVL) : in_vl;
  assign load    = CW'(lat_of(in_unit)) + CW'(vl_eff) - CW'(1);
  assign ubx     = UPAD'(unit_busy);
  assign unit_ok = (in_unit < UW'(NUNIT)) && !ubx[in_unit];
  assign a_ok    = !reg_busy[in_src_a] || win[in_src_a];
  assign b_ok    = !in_use_b || !reg_busy[in_src_b] || win[in_src_b];
  assign in_ready = unit_ok && !reg_busy[in_dst] && a_ok && b_ok;
  assign issue    = in_valid && in_ready;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [CW-1:0]  cnt, nxt;
    logic [VLW-1:0] cp;
    logic           is_dst, hit_d, hit_s;

    assign hit_d = issue && (in_dst == RW'(r));
    assign hit_s = issue && ((in_src_a == RW'(r)) || (in_use_b && in_src_b == RW'(r)));
    assign nxt   = (cnt == '0) ? '0 : cnt - CW'(1);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt    <= '0;
        cp     <= '0;
        is_dst <= 1'b0;
      end else if (hit_d) begin
        cnt    <= load;
        cp     <= vl_eff;
        is_dst <= 1'b1;
      end else if (hit_s) begin
        cnt    <= (load > nxt) ? load : nxt;
        is_dst <= 1'b0;
      end else begin
        cnt    <= nxt;
      end
    end

    assign reg_busy[r] = (cnt != '0);
    assign win[r]      = is_dst && (cp != '0) && (cnt == CW'(cp));
  end

  for (genvar u = 0; u < NUNIT; u++) begin : g_unit
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
      if (!rst_n)
        cnt <= '0;
      else if (issue && in_unit == UW'(u))
        cnt <= load;
      else if (cnt != '0)
        cnt <= cnt - CW'(1);
    end

    assign unit_busy[u] = (cnt != '0);
  end

  p_reserve_r2: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> ubx[$past(in_unit)] && reg_busy[$past(in_dst)]);

  p_src_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> reg_busy[$past(in_src_a)]);

  p_dst_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_busy[in_dst] |-> !issue);

  p_unit_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_unit < UW'(NUNIT)) && ubx[in_unit] |-> !issue);

  p_bad_unit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_unit >= UW'(NUNIT)) |-> !in_ready);

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && unit_busy == '0 |=> unit_busy == '0);

endmodule

// File: tb/test_vec_issue_sb.sv
module test_vec_issue_sb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [2:0] in_unit = '0, in_dst = '0, in_src_a = '0, in_src_b = '0;
  logic       in_use_b = 1'b0;
  logic [6:0] in_vl = '0;
  logic       in_ready, issue;
  logic [7:0] reg_busy;
  logic [5:0] unit_busy;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;

  vec_issue_sb i_vec_issue_sb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_unit(in_unit),
    .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .in_use_b(in_use_b), .in_vl(in_vl), .in_ready(in_ready), .issue(issue),
    .reg_busy(reg_busy), .unit_busy(unit_busy)
  );

  always #10 clk = ~clk;

  typedef struct packed {
    logic [2:0] u, d, a, b;
    logic       ub;
    logic [6:0] vl;
    logic [3:0] gap;
    logic [6:0] st;
  } ent_t;

  // unit codes: 0 vadd 3, 1 shift 4, 2 logic 2, 3 fadd 6, 4 fmul 7, 5 recip 14
  localparam ent_t TBL [15] = '{
    '{3'd0, 3'd1, 3'd2, 3'd3, 1'b1, 7'd4,   4'd0, 7'd0},   // start
    '{3'd2, 3'd4, 3'd5, 3'd6, 1'b1, 7'd2,   4'd0, 7'd0},   // R3 independent
    '{3'd1, 3'd0, 3'd1, 3'd0, 1'b0, 7'd3,   4'd0, 7'd1},   // R7 chain on V1
    '{3'd3, 3'd2, 3'd4, 3'd7, 1'b1, 7'd0,   4'd0, 7'd3},   // R4 dst and src busy
    '{3'd2, 3'd6, 3'd5, 3'd3, 1'b1, 7'd1,   4'd0, 7'd0},   // R3 after release
    '{3'd2, 3'd3, 3'd3, 3'd0, 1'b0, 7'd2,   4'd0, 7'd2},   // R5 unit held
    '{3'd5, 3'd1, 3'd0, 3'd0, 1'b0, 7'd2,   4'd0, 7'd0},   // R6 recip
    '{3'd1, 3'd5, 3'd1, 3'd0, 1'b0, 7'd0,   4'd0, 7'd13},  // R7 long chain
    '{3'd4, 3'd4, 3'd1, 3'd2, 1'b1, 7'd5,   4'd0, 7'd3},   // R11 merged hold
    '{3'd0, 3'd6, 3'd4, 3'd4, 1'b1, 7'd0,   4'd0, 7'd6},   // R7 both sources chain
    '{3'd0, 3'd0, 3'd4, 3'd0, 1'b0, 7'd0,   4'd0, 7'd4},   // R11 no second chain
    '{3'd0, 3'd1, 3'd2, 3'd3, 1'b1, 7'd4,   4'd4, 7'd0},   // producer
    '{3'd1, 3'd7, 3'd1, 3'd0, 1'b0, 7'd0,   4'd3, 7'd3},   // R8 missed slot
    '{3'd5, 3'd3, 3'd3, 3'd0, 1'b0, 7'd100, 4'd0, 7'd0},   // R9 clamp
    '{3'd5, 3'd0, 3'd0, 3'd0, 1'b0, 7'd0,   4'd0, 7'd77}   // R9 R5 long hold
  };

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  task automatic offer(input logic [2:0] u, d, a, b, input logic ub, input logic [6:0] vl);
    in_unit = u; in_dst = d; in_src_a = a; in_src_b = b; in_use_b = ub; in_vl = vl;
    in_valid = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 5000);
      finish_run();
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    offer(3'd0, 3'd1, 3'd2, 3'd3, 1'b1, 7'd4);
    in_valid = 1'b0;
    #1;
    chk(reg_busy == 8'h00 && unit_busy == 6'h00, "R12 flags clear after reset", {unit_busy, reg_busy}, 0);
    chk(in_ready == 1'b1, "R12 ready after reset", in_ready, 1);
    chk(issue == 1'b0, "R1 no start without valid", issue, 0);
    @(negedge clk);
    chk(reg_busy == 8'h00 && unit_busy == 6'h00, "R1 nothing reserved without valid", {unit_busy, reg_busy}, 0);

    for (int i = 0; i < 15; i++) begin
      ent_t e;
      int st;
      e = TBL[i];
      st = 0;
      repeat (int'(e.gap)) @(negedge clk);
      offer(e.u, e.d, e.a, e.b, e.ub, e.vl);
      #1;
      while (!in_ready) begin
        @(negedge clk);
        #1;
        st++;
      end
      chk(issue == 1'b1, "R1 issue follows valid and ready", issue, 1);
      @(negedge clk);
      in_valid = 1'b0;
      #1;
      chk(st == int'(e.st), $sformatf("row %0d stall cycles R3 R4 R5 R6 R7 R8 R9 R11", i), st, int'(e.st));
      chk(unit_busy[e.u] && reg_busy[e.d], $sformatf("row %0d R2 unit and destination reserved", i),
          {unit_busy, reg_busy}, 1);
    end

    // last row: recip, length 0, latency 14 -> flag high for 13 cycles
    repeat (12) @(negedge clk);
    #1;
    chk(unit_busy[5] == 1'b1 && reg_busy[0] == 1'b1, "R4 still held one cycle before release",
        {unit_busy, reg_busy}, 1);
    @(negedge clk);
    #1;
    chk(unit_busy == 6'h00 && reg_busy == 8'h00, "R4 exact release of unit and registers",
        {unit_busy, reg_busy}, 0);

    offer(3'd6, 3'd1, 3'd2, 3'd3, 1'b1, 7'd4);
    #1;
    chk(in_ready == 1'b0, "R10 code 6 not ready", in_ready, 0);
    repeat (3) @(negedge clk);
    offer(3'd7, 3'd1, 3'd2, 3'd3, 1'b1, 7'd4);
    #1;
    chk(in_ready == 1'b0, "R10 code 7 not ready", in_ready, 0);
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(unit_busy == 6'h00 && reg_busy == 8'h00, "R10 nothing reserved by bad codes",
        {unit_busy, reg_busy}, 0);

    offer(3'd5, 3'd2, 3'd4, 3'd0, 1'b0, 7'd64);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(unit_busy[5] && reg_busy[2] && reg_busy[4], "R2 reservation with length 64",
        {unit_busy, reg_busy}, 1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(unit_busy == 6'h00 && reg_busy == 8'h00, "R12 reset clears reservations",
        {unit_busy, reg_busy}, 0);

    finish_run();
  end
endmodule